// File: doc/BRIEF.md
# Over-Current Pulse-Skip Sequencer

This block holds the cycle-by-cycle overload logic of one synchronous buck channel. A one-clock pulse marks the start of each switching cycle. The block looks at a current-limit flag on that pulse. If the flag is high, the block blocks the high-side switch for that cycle. It then keeps blocking it for a fixed number of skip cycles.

After the skip phase comes an observation phase, in which high-side pulses are allowed again. Any new current-limit sighting in that phase marks the overload as sustained. The block then latches the channel off, and only an enable toggle or a reset clears it. A quiet observation phase returns the block to its armed condition.

The sequencer has four states. `OC_ARMED` is the normal state. Its transition `detect` (a tick with the flag high) leads to `OC_SKIP`. `OC_SKIP` leaves on `skip_done` (the tick that ends the skip phase) for `OC_WATCH`, or on `early_trip` (the flag high on that same tick) for `OC_TRIP`. `OC_WATCH` leaves on `trip` (the flag high on an observation tick) for `OC_TRIP`, or on `recover` (the last observation tick with the flag clear) for `OC_ARMED`. The transition `disable` (enable low) leads from every state to `OC_ARMED`.

Top module: `oc_pulse_skip_guard`

## Requirements
- R1: After reset, `hs_inhibit` and `oc_latch` are both 0. They stay 0 while the flag stays low on every tick.
- R2: With `enable` high and the block armed, a tick with `ilim_flag` high sets `hs_inhibit` to 1. This takes effect from the clock after that tick and lasts until the next tick.
- R3: For the SKIP_LEN (default 8) ticks after the detecting tick, `hs_inhibit` stays 1 and `oc_latch` stays 0. The flag value on those ticks has no effect: it neither restarts nor lengthens the skip phase.
- R4: On observation ticks SKIP_LEN+1 to SKIP_LEN+WATCH_LEN (defaults 9 to 16), counted from the detecting tick, `hs_inhibit` is 0 as long as the flag is clear.
- R5: A high flag on any observation tick sets both `oc_latch` and `hs_inhibit` to 1 from the next clock.
- R6: If all observation ticks see the flag clear, the block is armed again at the next tick. A flag on that next tick starts a full new sequence.
- R7: Once latched, both outputs stay 1 whatever the flag and the ticks do. Driving `enable` low clears both outputs at the next clock.
- R8: While `enable` is low, ticks with the flag high have no effect, and both outputs read 0.
- R9: The flag has no effect on clocks where `tick` is low.
- R10: An active-low reset clears a latched fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset (supply cycle) |
| enable | input | 1 | Channel enable; low clears the sequence and the latch |
| tick | input | 1 | One-clock pulse at the start of each switching cycle |
| ilim_flag | input | 1 | Current-limit detected flag, sampled on ticks |
| hs_inhibit | output | 1 | High blocks the high-side drive |
| oc_latch | output | 1 | Sustained over-current fault latched |

## Verification
The embedded properties check on every clock that the sequencer state does not move between ticks. They also check that a latched fault persists while the channel is enabled, that disable always returns the block to armed, that the skip phase cannot end early, that the window counter stays in range, and that a latch always comes with the inhibit. Only the scenarios can show the exact tick positions. These are the first skip tick, the boundary between tick 8 and tick 9, a trip on the first, a middle and the last observation tick, recovery after tick 16 followed by an immediate restart, and the clearing of a latch by enable and by reset.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Sequencer states of the over-current pulse-skip logic
    typedef enum logic [1:0] {
        OC_ARMED = 2'd0,
        OC_SKIP  = 2'd1,
        OC_WATCH = 2'd2,
        OC_TRIP  = 2'd3
    } oc_state_e;

endpackage

// File: rtl/ocp_window_counter.sv
module ocp_window_counter #(
    parameter int CNT_W   = 5,
    parameter int CNT_MAX = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CNT_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT);

endmodule

// File: rtl/ocp_seq_fsm.sv
module ocp_seq_fsm
    import ocp_pkg::*;
#(
    parameter int SKIP_LEN  = 8,
    parameter int WATCH_LEN = 8,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             ilim,
    input  logic [CNT_W-1:0] cnt,
    output oc_state_e        nxt_state,
    output logic             cnt_clr,
    output logic             cnt_inc
);

    localparam logic [CNT_W-1:0] SKIP_LAST = CNT_W'(SKIP_LEN);
    localparam logic [CNT_W-1:0] SKIP_END  = CNT_W'(SKIP_LEN + 1);
    localparam logic [CNT_W-1:0] WIN_END   = CNT_W'(SKIP_LEN + WATCH_LEN);

    oc_state_e        state;
    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = cnt + 1'b1;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OC_ARMED;
        end else begin
            state <= nxt_state;
        end
    end

    // Transition logic
    always_comb begin
        nxt_state = state;
        cnt_clr   = 1'b0;
        cnt_inc   = 1'b0;
        if (!enable) begin
            nxt_state = OC_ARMED;          // disable
            cnt_clr   = 1'b1;
        end else begin
            unique case (state)
                OC_ARMED: begin
                    if (tick && ilim) begin
                        nxt_state = OC_SKIP;   // detect
                        cnt_clr   = 1'b1;
                    end
                end
                OC_SKIP: begin
                    if (tick) begin
                        cnt_inc = 1'b1;
                        if (cnt_nx == SKIP_END) begin
                            nxt_state = ilim ? OC_TRIP : OC_WATCH; // early_trip / skip_done
                        end
                    end
                end
                OC_WATCH: begin
                    if (tick) begin
                        cnt_inc = 1'b1;
                        if (ilim) begin
                            nxt_state = OC_TRIP;    // trip
                        end else if (cnt_nx == WIN_END) begin
                            nxt_state = OC_ARMED;   // recover
                        end
                    end
                end
                OC_TRIP: begin
                    nxt_state = OC_TRIP;
                end
                default: begin
                    nxt_state = OC_ARMED;
                end
            endcase
        end
    end

    // R3
    skip_no_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == OC_SKIP && cnt < SKIP_LAST) |=> state == OC_SKIP);

    // R7
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == OC_TRIP) |=> state == OC_TRIP);

    // R8
    disable_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state == OC_ARMED);

    // R9
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(state));

endmodule

// File: rtl/ocp_drive_stage.sv
module ocp_drive_stage
    import ocp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  oc_state_e nxt_state,
    output logic      hs_inhibit,
    output logic      oc_latch
);

    // Output register, decoded from the upcoming state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_inhibit <= 1'b0;
            oc_latch   <= 1'b0;
        end else begin
            hs_inhibit <= (nxt_state == OC_SKIP) || (nxt_state == OC_TRIP);
            oc_latch   <= (nxt_state == OC_TRIP);
        end
    end

endmodule

// File: rtl/oc_pulse_skip_guard.sv
module oc_pulse_skip_guard
    import ocp_pkg::*;
#(
    parameter int SKIP_LEN  = 8,
    parameter int WATCH_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic ilim_flag,
    output logic hs_inhibit,
    output logic oc_latch
);

    localparam int CNT_MAX = SKIP_LEN + WATCH_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    oc_state_e        nxt_state;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] cnt;

    ocp_window_counter #(
        .CNT_W   (CNT_W),
        .CNT_MAX (CNT_MAX)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    ocp_seq_fsm #(
        .SKIP_LEN  (SKIP_LEN),
        .WATCH_LEN (WATCH_LEN),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .ilim      (ilim_flag),
        .cnt       (cnt),
        .nxt_state (nxt_state),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc)
    );

    ocp_drive_stage u_drv (
        .clk        (clk),
        .rst_n      (rst_n),
        .nxt_state  (nxt_state),
        .hs_inhibit (hs_inhibit),
        .oc_latch   (oc_latch)
    );

    // R5
    latch_has_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_latch |-> hs_inhibit);

    // R7
    latch_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_latch && enable) |=> oc_latch);

    // R8
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!oc_latch && !hs_inhibit));

endmodule

// File: tb/oc_pulse_skip_guard_tb.sv
module oc_pulse_skip_guard_tb;

    localparam int GAP = 4;

    typedef struct {
        int    due;
        logic  ei;
        logic  el;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic tick = 1'b0;
    logic ilim_flag = 1'b0;
    logic hs_inhibit;
    logic oc_latch;

    int   clk_cnt = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb[$];
    exp_t it;

    always #5 clk = ~clk;

    always @(posedge clk) clk_cnt = clk_cnt + 1;

    oc_pulse_skip_guard u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .tick       (tick),
        .ilim_flag  (ilim_flag),
        .hs_inhibit (hs_inhibit),
        .oc_latch   (oc_latch)
    );

    // Monitor: pop due items and compare
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= clk_cnt) begin
            it = sb.pop_front();
            checks = checks + 1;
            if (hs_inhibit !== it.ei || oc_latch !== it.el) begin
                fails = fails + 1;
                $display("FAIL %s: inhibit/latch = %b/%b, expected %b/%b (clk %0d)",
                         it.req, hs_inhibit, oc_latch, it.ei, it.el, clk_cnt);
            end
        end
    end

    task automatic push_exp(input logic ei, input logic el, input string req);
        exp_t e;
        e.due = clk_cnt + 1;
        e.ei  = ei;
        e.el  = el;
        e.req = req;
        sb.push_back(e);
    endtask

    // One switching cycle: tick with flag f, then clocks with flag = noise
    task automatic cyc(input logic f, input logic noise, input logic ei,
                       input logic el, input string req);
        for (int k = 0; k < GAP; k++) begin
            @(negedge clk);
            tick      = (k == 0);
            ilim_flag = (k == 0) ? f : noise;
            push_exp(ei, el, req);
        end
    endtask

    task automatic enable_off(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            enable    = 1'b0;
            tick      = k[0];
            ilim_flag = 1'b1;
            push_exp(1'b0, 1'b0, req);
        end
        @(negedge clk);
        enable    = 1'b1;
        tick      = 1'b0;
        ilim_flag = 1'b0;
        push_exp(1'b0, 1'b0, req);
    endtask

    // Detection plus the skip phase; noisy flag on skip ticks
    task automatic detect_and_skip();
        cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2");
        for (int t = 1; t <= 8; t++) begin
            cyc(logic'(t % 2), 1'b1, 1'b1, 1'b0, "R3");
        end
    endtask

    // Trip on observation tick n (9..16)
    task automatic trip_at(input int n);
        detect_and_skip();
        for (int t = 9; t < n; t++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        cyc(1'b1, 1'b0, 1'b1, 1'b1, "R5");
        for (int t = 0; t < 3; t++) cyc(logic'(t % 2), 1'b1, 1'b1, 1'b1, "R7");
    endtask

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        push_exp(1'b0, 1'b0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R1");
        // R9: flag between ticks in armed state
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R9");

        // Transient overload: skip, quiet watch, recovery
        detect_and_skip();
        for (int t = 9; t <= 16; t++) cyc(1'b0, 1'b1, 1'b0, 1'b0, "R4");
        cyc(1'b0, 1'b1, 1'b0, 1'b0, "R6");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R6");

        // R6: restart immediately on the tick after recovery
        detect_and_skip();
        for (int t = 9; t <= 16; t++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R4");
        detect_and_skip();
        for (int t = 9; t <= 16; t++) cyc(1'b0, 1'b0, 1'b0, 1'b0, "R4");

        // R5: trip on first observation tick, then R7 clear by enable
        trip_at(9);
        enable_off(1, "R7");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R7");

        // R5: trip in the middle of the window
        trip_at(12);
        enable_off(2, "R7");

        // R5: trip on the last observation tick
        trip_at(16);
        enable_off(3, "R7");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R7");

        // R8: flag ignored while disabled
        enable_off(6, "R8");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R8");

        // R10: reset clears a latch
        trip_at(10);
        @(negedge clk);
        rst_n = 1'b0;
        tick  = 1'b0;
        push_exp(1'b0, 1'b0, "R10");
        @(negedge clk);
        push_exp(1'b0, 1'b0, "R10");
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, "R10");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule